// File: doc/BRIEF.md
# Dual-Mode Segment Address Translator

This block converts a logical address, made of a 16-bit segment selector and an offset, into a flat address. It works in one of two modes. In real mode the selector is a paragraph number: the block shifts it left by four bits and adds a 16-bit offset. The 64KB segment limit is enforced, and an access that would run past the end of its segment is refused with general-protection code 13. In protected mode the selector picks an entry from a small on-chip table of 32-bit segment bases, and the result is that base plus a full 32-bit offset.

A request strobe starts a translation. One cycle later a valid strobe comes back with either an address or a fault. A write port loads segment bases into the table. The block comes out of reset in real mode and moves between modes only on an explicit mode-load pulse. The mode register is visible at an output so that the surrounding logic can see which rules apply.

Top module: `seg_xlat_top`

## Requirements
- R1: After reset the block is in real mode (`mode_o` = 0), all table entries read as zero, and `vld_o`, `fault_o`, `fault_code_o` and `addr_o` are all zero.
- R2: When `mode_set_i` is high at a clock edge, `mode_val_i` (0 = real, 1 = protected) is loaded into the mode register and `mode_o` shows it. A request in that same cycle still uses the previous mode. The mode never changes without such a pulse.
- R3: In real mode the address is `{sel_i, 4'b0000} + off_i[15:0]`, zero-extended to 32 bits. The carry into bit 20 is kept, so 0xFFFF:0xFFFF yields 0x0010FFEF. Offset bits [31:16] have no effect.
- R4: In real mode the access width follows `size_i`: 0 is 1 byte, 1 is 2 bytes, 2 and 3 are 4 bytes. If `off_i[15:0]` + bytes − 1 exceeds 0xFFFF, the result is a fault: `fault_o` = 1, `fault_code_o` = 13 (0x0D) and `addr_o` = 0.
- R5: A real-mode access that fits inside its 64KB segment never faults, whatever the selector and whether or not segments overlap.
- R6: In protected mode the table index is `sel_i[3+IW-1:3]`, where IW = log2(DEPTH). That is the selector index reduced modulo DEPTH. Selector bits [2:0] have no effect.
- R7: In protected mode the address is the base of the indexed entry plus `off_i`, modulo 2^32. No fault is raised for any size or offset.
- R8: When `tbl_we_i` is high at a clock edge, `tbl_base_i` is stored into entry `tbl_idx_i`. Requests from the next cycle onward see the new base.
- R9: `vld_o` is high exactly one cycle after a cycle with `req_i` high. `fault_o` is only ever high together with `vld_o`. In a cycle without valid, `addr_o`, `fault_o` and `fault_code_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_set_i | input | 1 | Load the mode register from `mode_val_i` |
| mode_val_i | input | 1 | New mode: 0 real, 1 protected |
| req_i | input | 1 | Translation request |
| sel_i | input | 16 | Segment selector |
| off_i | input | 32 | Offset (only low 16 bits used in real mode) |
| size_i | input | 2 | Access width: 0 byte, 1 word, 2/3 dword |
| tbl_we_i | input | 1 | Table write enable |
| tbl_idx_i | input | IW | Table entry to write |
| tbl_base_i | input | 32 | Segment base to write |
| mode_o | output | 1 | Current mode |
| vld_o | output | 1 | Result valid |
| fault_o | output | 1 | Result is a fault |
| fault_code_o | output | 8 | Exception code (13 on fault, else 0) |
| addr_o | output | 32 | Translated address, zero on fault |

## Verification
The assertions check the following on every cycle:
- the one-cycle request-to-valid relation, and that fault only appears with valid;
- the zero address and code 13 that accompany every fault;
- the absence of faults for protected-mode and single-byte real-mode requests;
- the 0x0010FFEF ceiling on real-mode results;
- the rule that the mode changes only after a load pulse.

The exact sums, the limit arithmetic for each access width, selector aliasing modulo the table depth and the visibility of table writes can only be shown by the bench's scenarios, which compare each result against a model.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;
  localparam int unsigned SEL_W  = 16;
  localparam int unsigned OFF_W  = 32;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned RSEG_W = 16;  // real-mode segment span in bits (64KB)
  localparam int unsigned IDX_LO = 3;   // low selector bits not used for lookup
  localparam logic [7:0]  EXC_GP = 8'd13;

  typedef enum logic {
    MODE_REAL = 1'b0,
    MODE_PROT = 1'b1
  } xlat_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_DWRD2 = 2'd3
  } acc_size_e;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    size_bytes = 3'd1;
      2'd1:    size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
  import seg_xlat_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IW-1:0]     widx_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic [IW-1:0]     ridx_i,
  output logic [ADDR_W-1:0] rdata_o
);
  logic [ADDR_W-1:0] base_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           base_q[g] <= '0;
      else if (we_i && widx_i == IW'(g))     base_q[g] <= wdata_i;
    end
  end

  assign rdata_o = base_q[ridx_i];
endmodule

// File: rtl/seg_real_path.sv
module seg_real_path
  import seg_xlat_pkg::*;
(
  input  logic [SEL_W-1:0]  seg_i,
  input  logic [RSEG_W-1:0] off_i,
  input  logic [1:0]        size_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              over_o
);
  logic [RSEG_W:0] last_byte;

  // last byte touched; a carry out of 16 bits means past the segment end
  assign last_byte = {1'b0, off_i} + (RSEG_W+1)'(size_bytes(size_i) - 3'd1);
  assign over_o    = last_byte[RSEG_W];
  assign addr_o    = (ADDR_W'(seg_i) << 4) + ADDR_W'(off_i);
endmodule

// File: rtl/seg_prot_path.sv
module seg_prot_path
  import seg_xlat_pkg::*;
(
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] addr_o
);
  assign addr_o = base_i + off_i;
endmodule

// File: rtl/seg_xlat_top.sv
module seg_xlat_top
  import seg_xlat_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_set_i,
  input  logic              mode_val_i,
  input  logic              req_i,
  input  logic [15:0]       sel_i,
  input  logic [31:0]       off_i,
  input  logic [1:0]        size_i,
  input  logic              tbl_we_i,
  input  logic [IW-1:0]     tbl_idx_i,
  input  logic [31:0]       tbl_base_i,
  output logic              mode_o,
  output logic              vld_o,
  output logic              fault_o,
  output logic [7:0]        fault_code_o,
  output logic [31:0]       addr_o
);
  xlat_mode_e        mode_q;
  logic              vld_q, fault_q;
  logic [ADDR_W-1:0] addr_q;

  logic [IW-1:0]     rd_idx;
  logic [ADDR_W-1:0] tbl_base;
  logic [ADDR_W-1:0] real_addr, prot_addr, nxt_addr;
  logic              real_over, nxt_fault;

  assign rd_idx = sel_i[IDX_LO +: IW];

  seg_desc_table #(.DEPTH(DEPTH)) u_tbl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tbl_we_i),
    .widx_i  (tbl_idx_i),
    .wdata_i (tbl_base_i),
    .ridx_i  (rd_idx),
    .rdata_o (tbl_base)
  );

  seg_real_path u_real (
    .seg_i  (sel_i),
    .off_i  (off_i[RSEG_W-1:0]),
    .size_i (size_i),
    .addr_o (real_addr),
    .over_o (real_over)
  );

  seg_prot_path u_prot (
    .base_i (tbl_base),
    .off_i  (off_i),
    .addr_o (prot_addr)
  );

  always_comb begin
    nxt_fault = 1'b0;
    nxt_addr  = prot_addr;
    if (mode_q == MODE_REAL) begin
      nxt_fault = real_over;
      nxt_addr  = real_over ? '0 : real_addr;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         mode_q <= MODE_REAL;
    else if (mode_set_i) mode_q <= xlat_mode_e'(mode_val_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      fault_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      vld_q   <= req_i;
      fault_q <= req_i & nxt_fault;
      addr_q  <= req_i ? nxt_addr : '0;
    end
  end

  assign mode_o       = mode_q;
  assign vld_o        = vld_q;
  assign fault_o      = fault_q;
  assign fault_code_o = fault_q ? EXC_GP : 8'd0;
  assign addr_o       = addr_q;
endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mode_set_i,
  input logic        req_i,
  input logic [1:0]  size_i,
  input logic        mode_o,
  input logic        vld_o,
  input logic        fault_o,
  input logic [7:0]  fault_code_o,
  input logic [31:0] addr_o
);
  // R2
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_set_i |=> $stable(mode_o));
  // R9
  req_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> vld_o);
  // R9
  idle_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!vld_o && !fault_o && addr_o == 32'd0 && fault_code_o == 8'd0));
  // R9
  fault_needs_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> vld_o);
  // R4
  fault_payload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (addr_o == 32'd0 && fault_code_o == 8'd13));
  // R7
  prot_no_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_o) |=> !fault_o);
  // R5
  byte_no_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !mode_o && size_i == 2'd0) |=> !fault_o);
  // R3
  real_ceiling_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !mode_o) |=> (addr_o <= 32'h0010FFEF));
endmodule

bind seg_xlat_top seg_xlat_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_set_i   (mode_set_i),
  .req_i        (req_i),
  .size_i       (size_i),
  .mode_o       (mode_o),
  .vld_o        (vld_o),
  .fault_o      (fault_o),
  .fault_code_o (fault_code_o),
  .addr_o       (addr_o)
);

// File: tb/tb_seg_xlat_top.sv
`timescale 1ns/1ps
module tb_seg_xlat_top;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned IW = $clog2(DEPTH);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic mode_set_i = 0, mode_val_i = 0, req_i = 0, tbl_we_i = 0;
  logic [15:0] sel_i = '0;
  logic [31:0] off_i = '0, tbl_base_i = '0;
  logic [1:0]  size_i = '0;
  logic [IW-1:0] tbl_idx_i = '0;
  logic mode_o, vld_o, fault_o;
  logic [7:0] fault_code_o;
  logic [31:0] addr_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic m_mode = 0;
  logic [31:0] m_tbl [DEPTH];

  always #4 clk_i = ~clk_i;

  seg_xlat_top #(.DEPTH(DEPTH)) dut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [32:0] expect_xlat(input logic [15:0] s, input logic [31:0] o, input logic [1:0] z);
    // {fault, addr}
    int unsigned n = (z == 0) ? 1 : (z == 1) ? 2 : 4;
    if (!m_mode) begin
      if (int'(o[15:0]) + n - 1 > 32'hFFFF) return {1'b1, 32'd0};
      return {1'b0, (32'(s) << 4) + 32'(o[15:0])};
    end
    return {1'b0, m_tbl[s[3 +: IW]] + o};
  endfunction

  task automatic xlat(input logic [15:0] s, input logic [31:0] o, input logic [1:0] z, input string req);
    logic [32:0] e = expect_xlat(s, o, z);
    @(negedge clk_i);
    req_i = 1; sel_i = s; off_i = o; size_i = z;
    @(negedge clk_i);
    req_i = 0;
    chk(vld_o === 1'b1, req, 64'(vld_o), 64'd1);
    chk(fault_o === e[32], req, 64'(fault_o), 64'(e[32]));
    chk(fault_code_o === (e[32] ? 8'd13 : 8'd0), req, 64'(fault_code_o), e[32] ? 64'd13 : 64'd0);
    chk(addr_o === e[31:0], req, 64'(addr_o), 64'(e[31:0]));
  endtask

  task automatic wr(input logic [IW-1:0] i, input logic [31:0] b);
    @(negedge clk_i);
    tbl_we_i = 1; tbl_idx_i = i; tbl_base_i = b;
    @(negedge clk_i);
    tbl_we_i = 0;
    m_tbl[i] = b;
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk_i);
    mode_set_i = 1; mode_val_i = m;
    @(negedge clk_i);
    mode_set_i = 0;
    m_mode = m;
    chk(mode_o === m, "R2", 64'(mode_o), 64'(m));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) m_tbl[i] = '0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(mode_o === 0 && vld_o === 0 && fault_o === 0 && fault_code_o === 0 && addr_o === 0,
        "R1", {mode_o, vld_o, fault_o, fault_code_o, addr_o}, 64'd0);
    rst_ni = 1;
    @(negedge clk_i);
    chk(mode_o === 0, "R1", 64'(mode_o), 64'd0);
    // R3 real-mode corners
    xlat(16'hFFFF, 32'h0000FFFF, 2'd0, "R3");
    chk(addr_o === 32'h0010FFEF, "R3", 64'(addr_o), 64'h10FFEF);
    xlat(16'h1234, 32'hABCD0010, 2'd0, "R3");
    xlat(16'h0000, 32'h0, 2'd3, "R3");
    // R4 limit per width
    xlat(16'h0100, 32'h0000FFFF, 2'd1, "R4");
    xlat(16'h0100, 32'h0000FFFE, 2'd1, "R4");
    xlat(16'h0100, 32'h0000FFFD, 2'd2, "R4");
    xlat(16'h0100, 32'h0000FFFC, 2'd2, "R4");
    xlat(16'h0100, 32'h0000FFFD, 2'd3, "R4");
    // R5 overlapping segments
    xlat(16'h1000, 32'h00000020, 2'd2, "R5");
    xlat(16'h1001, 32'h00000010, 2'd2, "R5");
    // R9 idle gives zero outputs
    @(negedge clk_i);
    chk(vld_o === 0 && addr_o === 0 && fault_o === 0, "R9", {vld_o, fault_o, addr_o}, 64'd0);
    // R1 table cleared at reset: protected read of entry 5
    set_mode(1);
    xlat(16'h0028, 32'h00000000, 2'd0, "R1");
    // R8 table write visible next cycle
    for (int i = 0; i < DEPTH; i++) wr(IW'(i), $urandom);
    wr(IW'(5), 32'hFFFF_FFF0);
    // R7 wraps modulo 2^32, no fault on dword at large offset
    xlat(16'h002B, 32'h00000020, 2'd2, "R7");
    // R6 low bits ignored, index modulo depth
    xlat(16'h0028 | 16'h7, 32'h1, 2'd0, "R6");
    xlat(16'((5 + DEPTH) << 3), 32'h1, 2'd0, "R6");
    // R2 request in the cycle of the switch uses old mode
    @(negedge clk_i);
    mode_set_i = 1; mode_val_i = 0; req_i = 1; sel_i = 16'h0010; off_i = 32'h0000FFFF; size_i = 2'd2;
    @(negedge clk_i);
    mode_set_i = 0; req_i = 0; m_mode = 0;
    chk(fault_o === 0 && addr_o === m_tbl[2] + 32'h0000FFFF, "R2", 64'(addr_o), 64'(m_tbl[2] + 32'h0000FFFF));
    chk(mode_o === 0, "R2", 64'(mode_o), 64'd0);
    // random mix
    for (int k = 0; k < 600; k++) begin
      logic [31:0] o = $urandom;
      if (k % 7 == 0) o[15:0] = 16'hFFFC | 16'($urandom % 4);
      if (k % 150 == 0) set_mode(~m_mode);
      if (k % 40 == 0) wr(IW'($urandom), $urandom);
      xlat(16'($urandom), o, 2'($urandom), m_mode ? "R7" : "R4");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule